// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Controller

This block holds a 256-word by 16-bit non-volatile-style store and exposes it through a single byte-wide register. Software does not send whole commands. It toggles three pins in that register (select, serial clock and data-in) one write at a time. The block watches for edges on the select and clock bits and runs a serial protocol. A command starts with a start bit, then a two-bit opcode and an eight-bit word address. Write data or read data follows. The serial data-out pin is read back through bit 0 of the same register.

The register is reached when an access inside the external-RAM window carries address bits [7:4] equal to 0x8. The surrounding window decode and bank logic sit outside this block. Opcode 01 writes a word, 10 reads a word and 11 erases a word. Opcode 00 carries a sub-command in address bits [7:6]:

| Bits [7:6] | Sub-command |
|---|---|
| 00 | lock (disable writes) |
| 01 | fill all words |
| 10 | wipe all words |
| 11 | unlock (enable writes) |

Every change to the storage is gated by a write-enable latch. Single-word writes and erases take effect only when select rises again after the data has been shifted in.

Top module: `serial_eeprom_ctrl`

## Requirements
- R1: After reset the write-enable latch is clear, the protocol is idle-null, the data-out bit reads 1 and every stored word reads 0xFFFF.
- R2: Only accesses with bus_addr[7:4] = 0x8 act on the controller. In the write byte, bit 7 is select, bit 6 is clock and bit 1 is data-in. A read hit returns data-out in bit 0 with bits 7:1 zero. Any other read returns 0xFF, and writes elsewhere change nothing.
- R3: Opcode 00 with address bits [7:6] = 11 sets the write-enable latch, and with 00 clears it. Both return to the null state.
- R4: Opcode 01 shifts in 16 data bits, MSB first. A later select rise stores them at the latched address when writes are enabled.
- R5: With the write-enable latch clear, no write, erase, fill or wipe changes any stored word.
- R6: For opcode 10, one further rising clock loads the word and data-out then reads 0. Each following falling clock presents the next bit, MSB first. After 16 bits the machine is null and further clocks leave data-out unchanged.
- R7: Opcode 00 with bits [7:6] = 01, followed by 16 data bits, sets every word to that value when writes are enabled.
- R8: Opcode 00 with bits [7:6] = 10, followed by 16 clocks, sets every word to 0xFFFF when writes are enabled.
- R9: Opcode 11 followed by 16 clocks and a select rise sets the addressed word to 0xFFFF and leaves other words unchanged.
- R10: A select rise that commits from the write state leaves data-out reading 1 (shift register preset to all ones).
- R11: In idle, rising clocks with data-in low are skipped. The first rising clock with data-in high is the start bit.
- R12: A select rise in any state other than the write state abandons the command and restarts at idle without touching storage.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_valid | input | 1 | Access strobe from the external-RAM window decode |
| bus_write | input | 1 | 1 = write access, 0 = read access |
| bus_addr | input | 8 | Low byte of the access address |
| bus_wdata | input | 8 | Write byte carrying the pin bits |
| bus_rdata | output | 8 | Read byte: data-out in bit 0 on a hit, else 0xFF |

## Verification
A corrupted protocol state shows up at the ports only through the data-out bit or through the words read back later. The dummy zero before a read, and the 1 after a commit, expose a wrong state on the next register read. A wrongly latched address, opcode or enable bit stays hidden until a complete read sequence returns a word, which can be hundreds of cycles later. For that reason every storage-changing scenario ends with a read back of the target word and of a neighbouring word.

// File: rtl/eeprom_pkg.sv
package eeprom_pkg;

    localparam int SEL_BIT = 7;
    localparam int CLK_BIT = 6;
    localparam int DIN_BIT = 1;
    localparam logic [3:0] REG_TAG = 4'h8;

    typedef enum logic [3:0] {
        ST_NULL,
        ST_IDLE,
        ST_CMD,
        ST_ADDR,
        ST_OP0,
        ST_OPWR,
        ST_OPRD,
        ST_OPER,
        ST_WRITE,
        ST_READ
    } ee_state_e;

    typedef enum logic [1:0] {
        SUB_LOCK   = 2'b00,
        SUB_FILL   = 2'b01,
        SUB_WIPE   = 2'b10,
        SUB_UNLOCK = 2'b11
    } ee_sub_e;

    typedef struct packed {
        logic sel;
        logic sck;
        logic din;
    } ee_pins_t;

    function automatic ee_pins_t unpack_pins(input logic [7:0] v);
        ee_pins_t p;
        p.sel = v[SEL_BIT];
        p.sck = v[CLK_BIT];
        p.din = v[DIN_BIT];
        return p;
    endfunction

    // States that take a data-in bit on each rising clock
    function automatic logic takes_bits(input ee_state_e s);
        return (s != ST_NULL) && (s != ST_IDLE) && (s != ST_READ);
    endfunction

    function automatic ee_state_e opcode_state(input logic [1:0] op);
        ee_state_e s;
        case (op)
            2'b00:   s = ST_OP0;
            2'b01:   s = ST_OPWR;
            2'b10:   s = ST_OPRD;
            default: s = ST_OPER;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/eeprom_bus_port.sv
module eeprom_bus_port
    import eeprom_pkg::*;
(
    input  logic       bus_valid,
    input  logic       bus_write,
    input  logic [7:0] bus_addr,
    input  logic [7:0] bus_wdata,
    input  logic       dout,
    output logic       hit_wr,
    output ee_pins_t   pins,
    output logic [7:0] bus_rdata
);
    logic hit;

    always_comb begin
        hit    = bus_valid && (bus_addr[7:4] == REG_TAG);
        hit_wr = hit && bus_write;
        pins   = unpack_pins(bus_wdata);
        if (hit && !bus_write) begin
            bus_rdata = {7'b0, dout};
        end else begin
            bus_rdata = 8'hFF;
        end
    end
endmodule

// File: rtl/eeprom_word_array.sv
module eeprom_word_array #(
    parameter int ADDR_W = 8,
    parameter int WORD_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [WORD_W-1:0] wdata,
    input  logic              fill,
    input  logic [WORD_W-1:0] fill_data,
    input  logic [ADDR_W-1:0] raddr,
    output logic [WORD_W-1:0] rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [WORD_W-1:0] mem [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_word
        always_ff @(posedge clk) begin
            if (rst) begin
                mem[g] <= '1;
            end else if (fill) begin
                mem[g] <= fill_data;
            end else if (we && (waddr == ADDR_W'(g))) begin
                mem[g] <= wdata;
            end
        end
    end

    assign rdata = mem[raddr];
endmodule

// File: rtl/eeprom_proto_fsm.sv
module eeprom_proto_fsm
    import eeprom_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int WORD_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              hit_wr,
    input  ee_pins_t          pins,
    input  logic [WORD_W-1:0] rd_word,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [WORD_W-1:0] mem_wdata,
    output logic              fill_en,
    output logic [WORD_W-1:0] fill_data,
    output logic              dout,
    output ee_state_e         state,
    output logic [WORD_W:0]   shreg,
    output logic              wen,
    output logic              sel_q
);
    localparam int SR_W  = WORD_W + 1;
    localparam int CNT_W = $clog2(WORD_W) + 1;
    localparam logic [CNT_W-1:0] CNT_OP   = CNT_W'(2);
    localparam logic [CNT_W-1:0] CNT_ADR  = CNT_W'(ADDR_W);
    localparam logic [CNT_W-1:0] CNT_WORD = CNT_W'(WORD_W);

    ee_state_e         st_q, st_n;
    logic [SR_W-1:0]   sr_q, sr_n;
    logic [CNT_W-1:0]  cnt_q, cnt_n;
    logic [1:0]        op_q, op_n;
    logic [ADDR_W-1:0] adr_q, adr_n;
    logic              wen_q, wen_n;
    logic              sel_r, sel_n;
    logic              sck_r, sck_n;
    ee_sub_e           sub;

    always_comb begin
        st_n      = st_q;
        sr_n      = sr_q;
        cnt_n     = cnt_q;
        op_n      = op_q;
        adr_n     = adr_q;
        wen_n     = wen_q;
        sel_n     = sel_r;
        sck_n     = sck_r;
        mem_we    = 1'b0;
        fill_en   = 1'b0;
        fill_data = '1;
        sub       = ee_sub_e'(adr_q[ADDR_W-1 -: 2]);
        if (hit_wr) begin
            sel_n = pins.sel;
            sck_n = pins.sck;
            // select rise: commit or restart
            if (!sel_r && pins.sel) begin
                if (st_q == ST_WRITE) begin
                    mem_we = wen_q;
                    sr_n   = '1;
                    st_n   = ST_NULL;
                end else begin
                    st_n = ST_IDLE;
                end
            end
            if (!sck_r && pins.sck) begin
                if (takes_bits(st_n)) begin
                    sr_n  = {sr_n[SR_W-2:0], pins.din};
                    cnt_n = cnt_n + 1'b1;
                end
                case (st_n)
                    ST_IDLE: begin
                        if (pins.din) begin
                            st_n  = ST_CMD;
                            cnt_n = '0;
                            sr_n  = '0;
                        end
                    end
                    ST_CMD: begin
                        if (cnt_n == CNT_OP) begin
                            st_n  = ST_ADDR;
                            cnt_n = '0;
                            op_n  = sr_n[1:0];
                        end
                    end
                    ST_ADDR: begin
                        if (cnt_n == CNT_ADR) begin
                            cnt_n = '0;
                            adr_n = sr_n[ADDR_W-1:0];
                            st_n  = opcode_state(op_n);
                            sub   = ee_sub_e'(adr_n[ADDR_W-1 -: 2]);
                            if (op_n == 2'b00) begin
                                if (sub == SUB_LOCK) begin
                                    wen_n = 1'b0;
                                    st_n  = ST_NULL;
                                end else if (sub == SUB_UNLOCK) begin
                                    wen_n = 1'b1;
                                    st_n  = ST_NULL;
                                end
                            end
                        end
                    end
                    ST_OP0: begin
                        if (cnt_n == CNT_WORD) begin
                            case (sub)
                                SUB_LOCK: begin
                                    wen_n = 1'b0;
                                    st_n  = ST_NULL;
                                end
                                SUB_FILL: begin
                                    st_n      = ST_WRITE;
                                    fill_en   = wen_q;
                                    fill_data = sr_n[WORD_W-1:0];
                                end
                                SUB_WIPE: begin
                                    st_n    = ST_WRITE;
                                    fill_en = wen_q;
                                end
                                default: begin
                                    wen_n = 1'b1;
                                    st_n  = ST_NULL;
                                end
                            endcase
                        end
                    end
                    ST_OPWR: begin
                        if (cnt_n == CNT_WORD) begin
                            cnt_n = '0;
                            st_n  = ST_WRITE;
                        end
                    end
                    ST_OPRD: begin
                        if (cnt_n == CNT_W'(1)) begin
                            sr_n  = {1'b0, rd_word};
                            cnt_n = '0;
                            st_n  = ST_READ;
                        end
                    end
                    ST_OPER: begin
                        if (cnt_n == CNT_WORD) begin
                            sr_n  = {1'b0, {WORD_W{1'b1}}};
                            cnt_n = '0;
                            st_n  = ST_WRITE;
                        end
                    end
                    default: ;
                endcase
            end else if (sck_r && !pins.sck) begin
                if (st_n == ST_READ) begin
                    sr_n  = {sr_n[SR_W-2:0], 1'b0};
                    cnt_n = cnt_n + 1'b1;
                    if (cnt_n == CNT_WORD) begin
                        cnt_n = '0;
                        st_n  = ST_NULL;
                    end
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q  <= ST_NULL;
            sr_q  <= '1;
            cnt_q <= '0;
            op_q  <= '0;
            adr_q <= '0;
            wen_q <= 1'b0;
            sel_r <= 1'b0;
            sck_r <= 1'b0;
        end else begin
            st_q  <= st_n;
            sr_q  <= sr_n;
            cnt_q <= cnt_n;
            op_q  <= op_n;
            adr_q <= adr_n;
            wen_q <= wen_n;
            sel_r <= sel_n;
            sck_r <= sck_n;
        end
    end

    assign mem_addr  = adr_q;
    assign mem_wdata = sr_q[WORD_W-1:0];
    assign dout      = sr_q[SR_W-1];
    assign state     = st_q;
    assign shreg     = sr_q;
    assign wen       = wen_q;
    assign sel_q     = sel_r;
endmodule

// File: rtl/serial_eeprom_ctrl.sv
module serial_eeprom_ctrl
    import eeprom_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int WORD_W = 16
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       bus_valid,
    input  logic       bus_write,
    input  logic [7:0] bus_addr,
    input  logic [7:0] bus_wdata,
    output logic [7:0] bus_rdata
);
    logic              hit_wr;
    ee_pins_t          pins;
    logic              dout;
    logic [WORD_W-1:0] rd_word;
    logic              mem_we;
    logic [ADDR_W-1:0] mem_addr;
    logic [WORD_W-1:0] mem_wdata;
    logic              fill_en;
    logic [WORD_W-1:0] fill_data;
    ee_state_e         state;
    logic [WORD_W:0]   shreg;
    logic              wen;
    logic              sel_q;

    eeprom_bus_port u_port (
        .bus_valid (bus_valid),
        .bus_write (bus_write),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .dout      (dout),
        .hit_wr    (hit_wr),
        .pins      (pins),
        .bus_rdata (bus_rdata)
    );

    eeprom_proto_fsm #(.ADDR_W(ADDR_W), .WORD_W(WORD_W)) u_fsm (
        .clk       (clk),
        .rst       (rst),
        .hit_wr    (hit_wr),
        .pins      (pins),
        .rd_word   (rd_word),
        .mem_we    (mem_we),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .fill_en   (fill_en),
        .fill_data (fill_data),
        .dout      (dout),
        .state     (state),
        .shreg     (shreg),
        .wen       (wen),
        .sel_q     (sel_q)
    );

    eeprom_word_array #(.ADDR_W(ADDR_W), .WORD_W(WORD_W)) u_array (
        .clk       (clk),
        .rst       (rst),
        .we        (mem_we),
        .waddr     (mem_addr),
        .wdata     (mem_wdata),
        .fill      (fill_en),
        .fill_data (fill_data),
        .raddr     (mem_addr),
        .rdata     (rd_word)
    );
endmodule

// File: rtl/eeprom_ctrl_checker.sv
module eeprom_ctrl_checker
    import eeprom_pkg::*;
#(
    parameter int WORD_W = 16
) (
    input logic            clk,
    input logic            rst,
    input logic            bus_valid,
    input logic            bus_write,
    input logic [7:0]      bus_addr,
    input logic [7:0]      bus_wdata,
    input logic [7:0]      bus_rdata,
    input ee_state_e       state,
    input logic [WORD_W:0] shreg,
    input logic            wen,
    input logic            sel_q,
    input logic            mem_we,
    input logic            fill_en
);
    logic hit, sel_rise;
    assign hit      = bus_valid && (bus_addr[7:4] == REG_TAG);
    assign sel_rise = hit && bus_write && bus_wdata[SEL_BIT] && !sel_q;

    AST_MISS_NO_EFFECT: assert property (@(posedge clk) disable iff (rst)
        (bus_valid && !hit) |=> ($stable(state) && $stable(shreg) && $stable(wen))); // R2

    AST_READ_UPPER_ZERO: assert property (@(posedge clk) disable iff (rst)
        (hit && !bus_write) |-> (bus_rdata[7:1] == 7'b0)); // R2

    AST_STORE_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (rst)
        (mem_we || fill_en) |-> wen); // R5

    AST_SINGLE_STROBE: assert property (@(posedge clk) disable iff (rst)
        $onehot0({mem_we, fill_en})); // R7

    AST_COMMIT_PRESET: assert property (@(posedge clk) disable iff (rst)
        (sel_rise && state == ST_WRITE) |=> (shreg == '1 && state == ST_NULL)); // R10

    AST_SELECT_RESTART: assert property (@(posedge clk) disable iff (rst)
        (sel_rise && state != ST_WRITE) |=> (state == ST_IDLE || state == ST_CMD)); // R12
endmodule

bind serial_eeprom_ctrl eeprom_ctrl_checker #(.WORD_W(WORD_W)) i_chk (
    .clk       (clk),
    .rst       (rst),
    .bus_valid (bus_valid),
    .bus_write (bus_write),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .state     (state),
    .shreg     (shreg),
    .wen       (wen),
    .sel_q     (sel_q),
    .mem_we    (mem_we),
    .fill_en   (fill_en)
);

// File: tb/test_serial_eeprom_ctrl.sv
module test_serial_eeprom_ctrl;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       bus_valid = 1'b0;
    logic       bus_write = 1'b0;
    logic [7:0] bus_addr = 8'h00;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    serial_eeprom_ctrl i_serial_eeprom_ctrl (
        .clk       (clk),
        .rst       (rst),
        .bus_valid (bus_valid),
        .bus_write (bus_write),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic bus_wr(input logic [7:0] a, input logic [7:0] v);
        @(negedge clk);
        bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = v;
        @(posedge clk);
        #1;
        bus_valid = 1'b0; bus_write = 1'b0;
    endtask

    task automatic bus_rd(input logic [7:0] a, output logic [7:0] v);
        @(negedge clk);
        bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a;
        #1;
        v = bus_rdata;
        bus_valid = 1'b0;
    endtask

    task automatic pins(input logic cs, input logic sk, input logic di);
        bus_wr(8'h80, {cs, sk, 4'b0, di, 1'b0});
    endtask

    task automatic dout(output logic b);
        logic [7:0] v;
        bus_rd(8'h80, v);
        b = v[0];
    endtask

    task automatic clk_bit(input logic di);
        pins(1'b1, 1'b0, di);
        pins(1'b1, 1'b1, di);
    endtask

    task automatic send_hdr(input logic [1:0] op, input logic [7:0] a, input int lead);
        pins(1'b0, 1'b0, 1'b0);
        pins(1'b1, 1'b0, 1'b0);
        for (int i = 0; i < lead; i++) clk_bit(1'b0);
        clk_bit(1'b1);
        clk_bit(op[1]);
        clk_bit(op[0]);
        for (int i = 7; i >= 0; i--) clk_bit(a[i]);
    endtask

    task automatic send_data(input logic [15:0] d);
        for (int i = 15; i >= 0; i--) clk_bit(d[i]);
    endtask

    task automatic commit();
        pins(1'b0, 1'b0, 1'b0);
        pins(1'b1, 1'b0, 1'b0);
    endtask

    task automatic write_word(input logic [7:0] a, input logic [15:0] d);
        send_hdr(2'b01, a, 0);
        send_data(d);
        commit();
    endtask

    task automatic read_word(input logic [7:0] a, output logic [15:0] w, output logic dummy);
        logic b;
        send_hdr(2'b10, a, 0);
        clk_bit(1'b0);
        dout(dummy);
        w = '0;
        for (int i = 0; i < 16; i++) begin
            pins(1'b1, 1'b0, 1'b0);
            dout(b);
            w = {w[14:0], b};
            pins(1'b1, 1'b1, 1'b0);
        end
        pins(1'b0, 1'b0, 1'b0);
    endtask

    task automatic expect_word(input string req, input logic [7:0] a, input logic [15:0] exp);
        logic [15:0] w;
        logic dm;
        read_word(a, w, dm);
        check(req, w, exp);
    endtask

    task automatic set_enable(input logic en);
        send_hdr(2'b00, en ? 8'hC0 : 8'h00, 0);
    endtask

    task automatic t_reset();
        logic [7:0] v;
        bus_rd(8'h80, v);
        check("R1 dout after reset", {8'h00, v}, 16'h0001);
        check("R2 upper read bits zero", {8'h00, v[7:1], 1'b0}, 16'h0000);
        bus_rd(8'h90, v);
        check("R2 miss read", {8'h00, v}, 16'h00FF);
        expect_word("R1 word erased after reset", 8'h33, 16'hFFFF);
    endtask

    task automatic t_locked_write();
        write_word(8'h12, 16'hBEEF);
        expect_word("R5 write while locked", 8'h12, 16'hFFFF);
    endtask

    task automatic t_write_path();
        logic b;
        set_enable(1'b1);
        send_hdr(2'b01, 8'h0A, 0);
        send_data(16'hBEEF);
        dout(b);
        check("R4 dout before commit", {15'b0, b}, 16'h0000);
        bus_wr(8'h90, 8'h00);
        bus_wr(8'h90, 8'h80);
        dout(b);
        check("R2 miss write ignored", {15'b0, b}, 16'h0000);
        commit();
        dout(b);
        check("R10 ready after commit", {15'b0, b}, 16'h0001);
        expect_word("R4 written word", 8'h0A, 16'hBEEF);
    endtask

    task automatic t_read_detail();
        logic [15:0] w;
        logic dm, b;
        read_word(8'h0A, w, dm);
        check("R6 dummy zero", {15'b0, dm}, 16'h0000);
        check("R6 word msb first", w, 16'hBEEF);
        pins(1'b1, 1'b1, 1'b0);
        pins(1'b1, 1'b0, 1'b0);
        dout(b);
        check("R6 null after 16 bits", {15'b0, b}, 16'h0001);
    endtask

    task automatic t_lock();
        set_enable(1'b0);
        write_word(8'h0A, 16'h1234);
        expect_word("R3 lock blocks write", 8'h0A, 16'hBEEF);
        set_enable(1'b1);
        write_word(8'h0A, 16'h1234);
        expect_word("R3 unlock allows write", 8'h0A, 16'h1234);
    endtask

    task automatic t_start_bit();
        send_hdr(2'b01, 8'h44, 3);
        send_data(16'hC0DE);
        commit();
        expect_word("R11 leading zeros skipped", 8'h44, 16'hC0DE);
    endtask

    task automatic t_abort();
        send_hdr(2'b01, 8'h45, 0);
        for (int i = 0; i < 8; i++) clk_bit(1'b0);
        commit();
        expect_word("R12 aborted write", 8'h45, 16'hFFFF);
    endtask

    task automatic t_erase_word();
        write_word(8'h20, 16'h1357);
        write_word(8'h21, 16'h2468);
        send_hdr(2'b11, 8'h20, 0);
        for (int i = 0; i < 16; i++) clk_bit(1'b0);
        commit();
        expect_word("R9 erased word", 8'h20, 16'hFFFF);
        expect_word("R9 neighbour kept", 8'h21, 16'h2468);
    endtask

    task automatic t_fill_wipe();
        send_hdr(2'b00, 8'h40, 0);
        send_data(16'h5A3C);
        commit();
        expect_word("R7 fill word 00", 8'h00, 16'h5A3C);
        expect_word("R7 fill word 7F", 8'h7F, 16'h5A3C);
        expect_word("R7 fill word FF", 8'hFF, 16'h5A3C);
        send_hdr(2'b00, 8'h80, 0);
        send_data(16'hFFFF);
        commit();
        expect_word("R8 wipe word 00", 8'h00, 16'hFFFF);
        expect_word("R8 wipe word FF", 8'hFF, 16'hFFFF);
        set_enable(1'b0);
        send_hdr(2'b00, 8'h40, 0);
        send_data(16'h0000);
        commit();
        expect_word("R5 fill while locked", 8'h10, 16'hFFFF);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_locked_write();
        t_write_path();
        t_read_detail();
        t_lock();
        t_start_bit();
        t_abort();
        t_erase_word();
        t_fill_wipe();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule